// File: doc/BRIEF.md
# Three-Channel PWM Generator with Frame-Sync Restart

This block produces three pulse-width-modulated outputs for driving things such as a panel backlight or an audio level stage in a display pipeline. Each channel runs a prescaler and a period counter off the pixel clock. The output is high for the first part of every period, set by a duty value. A polarity bit inverts the output, and an enable bit parks it low.

Each channel can run freely or restart its period on a rising edge of one of two frame-sync inputs. One of these syncs comes from the incoming video, the other from the display timing. Each sync input passes through a two-flop synchronizer before its edge is detected. The second output pin can be switched to carry the complement of the first channel instead of its own channel.

Software programs the channels through a byte-wide write port. New period and duty values are staged and only take effect at the next period boundary or the next sync restart, so a reprogrammed channel never emits a truncated pulse.

Top module: `pwm_vsync_multi`

## Requirements
- R1: After reset every channel is enabled with normal polarity, and the pin-2 source and alternate-path bits are 0. Channel 0 resets to period 0x100, prescale 1, duty 0x080 and free-running mode. Channel 1 resets to period 0x200, prescale 3, duty 0x100 and input-sync mode. Channel 2 resets to period 0x300, prescale 0, duty 0x150 and input-sync mode. All pins read 0 while reset is held.
- R2: Channel c owns byte addresses 8c+0 to 8c+4, which map as follows:
  - +0: period[7:0].
  - +1: prescale in bits [7:4] and period[11:8] in bits [3:0].
  - +2: duty[7:0].
  - +3: duty[11:8] in bits [3:0].
  - +4: control, with bit 0 enable, bit 1 polarity and bits [3:2] sync mode.
- R3: An enabled channel repeats every period×(prescale+1) clocks. For normal polarity the output is high for min(duty, period)×(prescale+1) of those clocks.
- R4: With normal polarity, a duty of 0 keeps the output constantly low, and a duty of period or more keeps it constantly high.
- R5: Polarity 1 inverts the output of an enabled channel.
- R6: A disabled channel drives 0 whatever its polarity, and it holds its counters at zero.
- R7: In sync mode 2'b11 a rising edge on vsyncSrc restarts the period. If vsyncSrc rises before clock edge 1, the first cycle of the new period appears on the pin after clock edge 4. vsyncDisp has no effect in this mode.
- R8: In sync mode 2'b10 a rising edge on vsyncDisp restarts the period with the same 4-edge timing. vsyncSrc has no effect in this mode.
- R9: In sync modes 2'b00 and 2'b01 the channel runs freely and ignores both sync inputs.
- R10: Period and duty writes are staged. They take effect only at the next period wrap or sync restart.
- R11: Bit 4 of channel 0's control byte selects the source of pwmPin[1]. A 0 gives channel 1, and a 1 gives the complement of pwmPin[0].
- R12: Bit 5 of channel 0's control byte drives altPathEn.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel-domain clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 5 | Register byte address |
| wrData | input | 8 | Register write data |
| vsyncSrc | input | 1 | Frame sync of the incoming video, asynchronous |
| vsyncDisp | input | 1 | Frame sync of the display timing, asynchronous |
| pwmPin | output | 3 | PWM outputs, one per pin |
| altPathEn | output | 1 | Alternate output path enable from channel 0 control |

## Verification
The bench aligns a channel with a sync pulse. It then fires a second pulse at a phase where the old and the restarted waveforms differ. A restart that honours the wrong sync input, or that ignores the selected one, therefore shows up as a pulse in the wrong cycle. The bench changes the duty in the middle of a period and watches the rest of that period. A design without staging would emit a runt pulse in that window. Further checks on the duty extremes, on prescale counts above zero and on a disabled channel with inverted polarity catch off-by-one wrap logic, a prescaler that counts one clock too few or too many, and a disabled channel that idles high.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  localparam int CH_N   = 3;
  localparam int PER_W  = 12;
  localparam int REF_W  = 4;
  localparam int BYTE_W = 8;
  localparam int SUB_W  = 3;
  localparam int ADDR_W = SUB_W + 2;
  localparam int CH_AW  = ADDR_W - SUB_W;

  localparam logic [SUB_W-1:0] SUB_PER_LO  = 3'd0;
  localparam logic [SUB_W-1:0] SUB_PER_HI  = 3'd1;
  localparam logic [SUB_W-1:0] SUB_DUTY_LO = 3'd2;
  localparam logic [SUB_W-1:0] SUB_DUTY_HI = 3'd3;
  localparam logic [SUB_W-1:0] SUB_CTRL    = 3'd4;

  localparam int CTRL_EN_BIT   = 0;
  localparam int CTRL_POL_BIT  = 1;
  localparam int CTRL_MODE_LSB = 2;
  localparam int CTRL_PIN2_BIT = 4;
  localparam int CTRL_ALT_BIT  = 5;

  typedef enum logic [1:0] {
    SYNC_FREE0 = 2'b00,
    SYNC_FREE1 = 2'b01,
    SYNC_DISP  = 2'b10,
    SYNC_SRC   = 2'b11
  } syncMode_e;

  typedef struct packed {
    logic [PER_W-1:0] period;
    logic [REF_W-1:0] refCnt;
    logic [PER_W-1:0] duty;
    logic             en;
    logic             pol;
  } chRun_t;

  typedef struct packed {
    logic [CH_N-1:0] restart;
    logic            pin2FromCh1;
  } ctlStrobe_t;

  function automatic chRun_t resetRun(input int idx);
    chRun_t r;
    r.period = PER_W'((idx + 1) * 256);
    case (idx)
      0:       begin r.refCnt = REF_W'(1); r.duty = PER_W'('h080); end
      1:       begin r.refCnt = REF_W'(3); r.duty = PER_W'('h100); end
      default: begin r.refCnt = REF_W'(0); r.duty = PER_W'('h150); end
    endcase
    r.en  = 1'b1;
    r.pol = 1'b0;
    return r;
  endfunction

  function automatic syncMode_e resetMode(input int idx);
    return (idx == 0) ? SYNC_FREE0 : SYNC_SRC;
  endfunction
endpackage

// File: rtl/pwm_sync2.sv
module pwm_sync2 (
  input  logic clk,
  input  logic rstN,
  input  logic din,
  output logic dout
);
  logic [1:0] stage;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stage <= '0;
    else       stage <= {stage[0], din};
  end

  assign dout = stage[1];
endmodule

// File: rtl/pwm_ctrl.sv
module pwm_ctrl
  import pwm_pkg::*;
(
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   wrEn,
  input  logic [ADDR_W-1:0]      wrAddr,
  input  logic [BYTE_W-1:0]      wrData,
  input  logic                   vsyncSrc,
  input  logic                   vsyncDisp,
  output chRun_t [CH_N-1:0]      runCfg,
  output ctlStrobe_t             strobe,
  output logic                   altPathEn
);
  logic [CH_AW-1:0] chSel;
  logic [SUB_W-1:0] sub;
  chRun_t [CH_N-1:0] runQ;
  syncMode_e modeQ [CH_N];
  logic pin2Q, altQ;
  logic srcSync, dispSync, srcDly, dispDly, srcRise, dispRise;
  logic [CH_N-1:0] restartC;

  assign chSel = wrAddr[ADDR_W-1:SUB_W];
  assign sub   = wrAddr[SUB_W-1:0];

  pwm_sync2 u_syncSrc  (.clk(clk), .rstN(rstN), .din(vsyncSrc),  .dout(srcSync));
  pwm_sync2 u_syncDisp (.clk(clk), .rstN(rstN), .din(vsyncDisp), .dout(dispSync));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      srcDly  <= 1'b0;
      dispDly <= 1'b0;
    end else begin
      srcDly  <= srcSync;
      dispDly <= dispSync;
    end
  end

  assign srcRise  = srcSync & ~srcDly;
  assign dispRise = dispSync & ~dispDly;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int c = 0; c < CH_N; c++) begin
        runQ[c]  <= resetRun(c);
        modeQ[c] <= resetMode(c);
      end
      pin2Q <= 1'b0;
      altQ  <= 1'b0;
    end else if (wrEn) begin
      for (int c = 0; c < CH_N; c++) begin
        if (chSel == CH_AW'(c)) begin
          case (sub)
            SUB_PER_LO:  runQ[c].period[BYTE_W-1:0] <= wrData;
            SUB_PER_HI: begin
              runQ[c].period[PER_W-1:BYTE_W] <= wrData[PER_W-BYTE_W-1:0];
              runQ[c].refCnt <= wrData[BYTE_W-1:BYTE_W-REF_W];
            end
            SUB_DUTY_LO: runQ[c].duty[BYTE_W-1:0] <= wrData;
            SUB_DUTY_HI: runQ[c].duty[PER_W-1:BYTE_W] <= wrData[PER_W-BYTE_W-1:0];
            SUB_CTRL: begin
              runQ[c].en  <= wrData[CTRL_EN_BIT];
              runQ[c].pol <= wrData[CTRL_POL_BIT];
              modeQ[c]    <= syncMode_e'(wrData[CTRL_MODE_LSB +: 2]);
              if (c == 0) begin
                pin2Q <= wrData[CTRL_PIN2_BIT];
                altQ  <= wrData[CTRL_ALT_BIT];
              end
            end
            default: ;
          endcase
        end
      end
    end
  end

  always_comb begin
    for (int c = 0; c < CH_N; c++) begin
      case (modeQ[c])
        SYNC_SRC:  restartC[c] = srcRise;
        SYNC_DISP: restartC[c] = dispRise;
        default:   restartC[c] = 1'b0;
      endcase
    end
  end

  assign runCfg             = runQ;
  assign strobe.restart     = restartC;
  assign strobe.pin2FromCh1 = pin2Q;
  assign altPathEn          = altQ;

  // R7
  src_rise_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    srcRise |=> !srcRise);

  // R2
  ctrl_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr == ADDR_W'(SUB_CTRL)) |=>
      (runCfg[0].en == $past(wrData[CTRL_EN_BIT]) &&
       runCfg[0].pol == $past(wrData[CTRL_POL_BIT])));
endmodule

// File: rtl/pwm_chan.sv
module pwm_chan
  import pwm_pkg::*;
#(
  parameter int CH_IDX = 0
) (
  input  logic   clk,
  input  logic   rstN,
  input  chRun_t run,
  input  logic   restart,
  output logic   chOut
);
  logic [REF_W-1:0] pre;
  logic [PER_W-1:0] cnt, actPer, actDuty;
  logic [PER_W:0]   nextCnt;
  logic             wrapHit, rawHigh, outQ;

  assign nextCnt = {1'b0, cnt} + 1'b1;
  assign wrapHit = nextCnt >= {1'b0, actPer};
  assign rawHigh = cnt < actDuty;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pre     <= '0;
      cnt     <= '0;
      actPer  <= resetRun(CH_IDX).period;
      actDuty <= resetRun(CH_IDX).duty;
      outQ    <= 1'b0;
    end else if (!run.en) begin
      pre     <= '0;
      cnt     <= '0;
      actPer  <= run.period;
      actDuty <= run.duty;
      outQ    <= 1'b0;
    end else begin
      outQ <= rawHigh ^ run.pol;
      if (restart) begin
        pre     <= '0;
        cnt     <= '0;
        actPer  <= run.period;
        actDuty <= run.duty;
      end else if (pre >= run.refCnt) begin
        pre <= '0;
        if (wrapHit) begin
          cnt     <= '0;
          actPer  <= run.period;
          actDuty <= run.duty;
        end else begin
          cnt <= nextCnt[PER_W-1:0];
        end
      end else begin
        pre <= pre + 1'b1;
      end
    end
  end

  assign chOut = outQ;

  // R3
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    (run.en && actPer > PER_W'(1)) |-> (cnt < actPer));

  // R7
  restart_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (run.en && restart) |=> (cnt == '0 && pre == '0));

  // R6
  disabled_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    !run.en |=> !chOut);

  // R4
  duty_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (run.en && actDuty == '0) |=> (chOut == $past(run.pol)));
endmodule

// File: rtl/pwm_datapath.sv
module pwm_datapath
  import pwm_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  chRun_t [CH_N-1:0]    runCfg,
  input  ctlStrobe_t           strobe,
  output logic [CH_N-1:0]      pwmPin
);
  logic [CH_N-1:0] chOut;

  for (genvar g = 0; g < CH_N; g++) begin : gChan
    pwm_chan #(.CH_IDX(g)) u_chan (
      .clk     (clk),
      .rstN    (rstN),
      .run     (runCfg[g]),
      .restart (strobe.restart[g]),
      .chOut   (chOut[g])
    );
  end

  always_comb begin
    pwmPin = chOut;
    if (strobe.pin2FromCh1) pwmPin[1] = ~chOut[0];
  end
endmodule

// File: rtl/pwm_vsync_multi.sv
module pwm_vsync_multi
  import pwm_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [BYTE_W-1:0] wrData,
  input  logic              vsyncSrc,
  input  logic              vsyncDisp,
  output logic [CH_N-1:0]   pwmPin,
  output logic              altPathEn
);
  chRun_t [CH_N-1:0] runCfg;
  ctlStrobe_t strobe;

  pwm_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .wrEn      (wrEn),
    .wrAddr    (wrAddr),
    .wrData    (wrData),
    .vsyncSrc  (vsyncSrc),
    .vsyncDisp (vsyncDisp),
    .runCfg    (runCfg),
    .strobe    (strobe),
    .altPathEn (altPathEn)
  );

  pwm_datapath u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .runCfg (runCfg),
    .strobe (strobe),
    .pwmPin (pwmPin)
  );
endmodule

// File: tb/tb_pwm_vsync_multi.sv
`timescale 1ns/1ps
module tb_pwm_vsync_multi;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0;
  logic [4:0] wrAddr = '0;
  logic [7:0] wrData = '0;
  logic vsyncSrc = 1'b0;
  logic vsyncDisp = 1'b0;
  logic [2:0] pwmPin;
  logic altPathEn;
  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  pwm_vsync_multi dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .vsyncSrc(vsyncSrc), .vsyncDisp(vsyncDisp), .pwmPin(pwmPin), .altPathEn(altPathEn)
  );

  // per, prescale, duty, pol, en, expected high count per window
  localparam logic [45:0] VEC [8] = '{
    {12'd10,  4'd0, 12'd3,   1'b0, 1'b1, 16'd3},
    {12'd10,  4'd2, 12'd7,   1'b0, 1'b1, 16'd21},
    {12'd12,  4'd1, 12'd0,   1'b0, 1'b1, 16'd0},
    {12'd8,   4'd0, 12'd8,   1'b0, 1'b1, 16'd8},
    {12'd9,   4'd0, 12'd20,  1'b0, 1'b1, 16'd9},
    {12'd10,  4'd0, 12'd3,   1'b1, 1'b1, 16'd7},
    {12'd16,  4'd3, 12'd4,   1'b1, 1'b0, 16'd0},
    {12'd300, 4'd0, 12'd291, 1'b0, 1'b1, 16'd291}
  };

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk); wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk); wrEn = 1'b0;
  endtask

  task automatic setCh2(input logic [11:0] per, input logic [3:0] pre,
                        input logic [11:0] duty, input logic [7:0] ctrl);
    wr(5'd16, per[7:0]);
    wr(5'd17, {pre, per[11:8]});
    wr(5'd18, duty[7:0]);
    wr(5'd19, {4'd0, duty[11:8]});
    wr(5'd20, ctrl);
  endtask

  task automatic pulseSrc();
    @(negedge clk); vsyncSrc = 1'b1;
    repeat (3) @(negedge clk);
    vsyncSrc = 1'b0;
  endtask

  // pulse at negedge k=0, sample after edges k=1..7 on pin 2
  task automatic probe(input bit s, input bit dsp, input bit expRst, input string req);
    logic v4, v5, v7;
    v4 = 1'b0; v5 = 1'b0; v7 = 1'b0;
    @(negedge clk); vsyncSrc = s; vsyncDisp = dsp;
    for (int k = 1; k <= 7; k++) begin
      @(negedge clk);
      if (k == 4) v4 = pwmPin[2];
      if (k == 5) v5 = pwmPin[2];
      if (k == 7) v7 = pwmPin[2];
      if (k == 3) begin vsyncSrc = 1'b0; vsyncDisp = 1'b0; end
    end
    if (expRst) begin
      chk({req, " restart pulse at edge 4"}, int'(v4), 1);
      chk({req, " restart low at edge 5"}, int'(v5), 0);
    end else begin
      chk({req, " no restart: edge 4 low"}, int'(v4), 0);
      chk({req, " no restart: old phase high at edge 7"}, int'(v7), 1);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int h0, h1, h2, mism;
    repeat (3) @(negedge clk);
    // R1 reset state at pins
    chk("R1 pins in reset", int'(pwmPin), 0);
    chk("R12 altPathEn in reset", int'(altPathEn), 0);
    rstN = 1'b1;
    repeat (4) @(negedge clk);
    h0 = 0; h1 = 0; h2 = 0;
    for (int i = 0; i < 2048; i++) begin
      @(negedge clk);
      if (pwmPin[0]) h0++;
      if (pwmPin[1]) h1++;
      if (i < 768 && pwmPin[2]) h2++;
    end
    chk("R1 ch0 default duty", h0, 1024);
    chk("R1 ch1 default duty", h1, 1024);
    chk("R1 ch2 default duty", h2, 336);

    // R3 R4 R5 R6 table on channel 2, input-sync mode to load staged values
    foreach (VEC[v]) begin
      logic [11:0] per, duty;
      logic [3:0] pre;
      logic pol, en;
      int expH, len, cnt;
      {per, pre, duty, pol, en} = VEC[v][45:16];
      expH = int'(VEC[v][15:0]);
      len = int'(per) * (int'(pre) + 1);
      setCh2(per, pre, duty, {4'd0, 2'b11, pol, en});
      pulseSrc();
      repeat (6) @(negedge clk);
      cnt = 0;
      for (int i = 0; i < len; i++) begin
        @(negedge clk);
        if (pwmPin[2]) cnt++;
      end
      chk($sformatf("R3/R4/R5/R6 vector %0d high count", v), cnt, expH);
    end

    // R7: input sync restarts, display sync ignored
    setCh2(12'd10, 4'd0, 12'd1, 8'h0D);
    probe(1'b1, 1'b0, 1'b1, "R7");
    repeat (9) @(negedge clk);
    probe(1'b0, 1'b1, 1'b0, "R7");
    repeat (2) @(negedge clk);
    // R8: display sync restarts, input sync ignored
    wr(5'd20, 8'h09);
    probe(1'b0, 1'b1, 1'b1, "R8");
    repeat (9) @(negedge clk);
    probe(1'b1, 1'b0, 1'b0, "R8");
    // R9: free-running ignores both
    wr(5'd20, 8'h01);
    probe(1'b1, 1'b1, 1'b0, "R9");

    // R10: duty change mid-period waits for the wrap
    setCh2(12'd10, 4'd0, 12'd2, 8'h0D);
    begin
      int lowBad, hiCnt;
      lowBad = 0; hiCnt = 0;
      @(negedge clk); vsyncSrc = 1'b1;
      for (int k = 1; k <= 23; k++) begin
        @(negedge clk);
        if (k >= 9 && k <= 13 && pwmPin[2]) lowBad++;
        if (k >= 14 && pwmPin[2]) hiCnt++;
        if (k == 3) vsyncSrc = 1'b0;
        if (k == 7) begin wrEn = 1'b1; wrAddr = 5'd18; wrData = 8'd8; end
        if (k == 8) wrEn = 1'b0;
      end
      chk("R10 no runt after mid-period write", lowBad, 0);
      chk("R10 new duty after wrap", hiCnt, 8);
    end

    // R11: pin 1 carries complement of pin 0
    wr(5'd4, 8'h11);
    repeat (2) @(negedge clk);
    mism = 0; h0 = 0;
    for (int i = 0; i < 512; i++) begin
      @(negedge clk);
      if (pwmPin[1] == pwmPin[0]) mism++;
      if (pwmPin[0]) h0++;
    end
    chk("R11 pin1 equals inverted pin0", mism, 0);
    chk("R11 ch0 still running", h0, 256);

    // R12
    wr(5'd4, 8'h21);
    @(negedge clk);
    chk("R12 altPathEn set", int'(altPathEn), 1);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule